// File: doc/BRIEF.md
# Two-Road Traffic Light Sequencer

This block runs the lamps at a crossing of a main road and a side road. Each road has red, yellow and green lamps. A seconds strobe is made from the system clock. The controller moves through four timed phases in a fixed loop. The phases are main-go (main green, side red), main-warn (main yellow, side red), side-go (main red, side green) and side-warn (main red, side yellow). The controller also keeps a two-digit decimal countdown of the seconds left in the current phase.

Each phase moves to the next on the strobe that follows a shown count of 1. The four transitions are main-go to main-warn, main-warn to side-go, side-go to side-warn and side-warn back to main-go. The new phase's full duration is loaded on that same strobe. A scanner drives an eight-position common-anode seven-segment display, one position at a time. It shows the ones digit on position 0 and the tens digit on position 1. All other positions are blank. Every output is active-low. The phase durations and both divide ratios are parameters. Tests can therefore run with short seconds while the defaults suit a 48 MHz clock.

Top module: `traffic_ctrl`

## Requirements
- R1: While `rst_n` is low, the block is in main-go with count 45 loaded and the scanner at position 0 (`dig_sel_n` = 8'hFE). Position 0 shows the digit 5.
- R2: The phases loop in this order: main-go, main-warn, side-go, side-warn, then main-go again. Each step happens only on a seconds strobe.
- R3: Main-go lasts MAIN_GO_S seconds (45 by default). The main green lamp and the side red lamp are lit.
- R4: Side-go lasts SIDE_GO_S seconds (25 by default). The side green lamp and the main red lamp are lit.
- R5: Each road's yellow phase lasts WARN_S seconds (5 by default). The other road stays red during it.
- R6: Each road has exactly one lamp lit. A road showing green or yellow forces the other road to red. The two greens are never lit together.
- R7: The countdown is held as two BCD digits. It starts at the phase duration and drops by one on each strobe down to 1. On the strobe after 1, the next phase's duration is loaded. The countdown never shows 0.
- R8: A strobe occurs every SEC_DIV clocks. After reset is released, the lamps and the count change only on clock edges numbered k·SEC_DIV (k ≥ 1).
- R9: Lamps, digit selects and segments are active-low. Segment bits are `seg_n[0]`=a through `seg_n[6]`=g. The active-high patterns for digits 0..9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R10: Exactly one digit select is low at any time. The scan position moves up by one every SCAN_DIV clocks and wraps from 7 to 0. Position 0 carries the ones digit and position 1 carries the tens digit.
- R11: Positions 2 to 7 are blank: `seg_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active-low |
| main_red_n | output | 1 | Main-road red lamp, active-low |
| main_yel_n | output | 1 | Main-road yellow lamp, active-low |
| main_grn_n | output | 1 | Main-road green lamp, active-low |
| side_red_n | output | 1 | Side-road red lamp, active-low |
| side_yel_n | output | 1 | Side-road yellow lamp, active-low |
| side_grn_n | output | 1 | Side-road green lamp, active-low |
| dig_sel_n | output | POSITIONS (8) | One-hot digit select, active-low |
| seg_n | output | 7 | Segments a..g, active-low |

## Verification
A phase change and a countdown reload fall on the same seconds strobe. The step on that strobe is a load of the next duration, not a decrement. A short SEC_DIV makes the whole loop run twice. The bench samples lamps and digits right after each strobe and again just before the next one. Because SEC_DIV is a multiple of SCAN_DIV, every strobe edge is also a scan step. The bench checks that the digit shown on each position across that edge comes from the new count, and that the scan order does not break.

// File: rtl/tl_pkg.sv
package tl_pkg;

    typedef enum logic [1:0] {
        PH_MAIN_GO   = 2'd0,
        PH_MAIN_WARN = 2'd1,
        PH_SIDE_GO   = 2'd2,
        PH_SIDE_WARN = 2'd3
    } phase_e;

    // Internal lamp set, active-high.
    typedef struct packed {
        logic red;
        logic yellow;
        logic green;
    } lamp_t;

    localparam int SEG_W = 7;

    // Active-high segment pattern, bit 0 = a .. bit 6 = g; blank outside 0..9.
    function automatic logic [SEG_W-1:0] seg_pattern(input logic [3:0] digit);
        logic [SEG_W-1:0] p;
        unique case (digit)
            4'd0:    p = 7'h3F;
            4'd1:    p = 7'h06;
            4'd2:    p = 7'h5B;
            4'd3:    p = 7'h4F;
            4'd4:    p = 7'h66;
            4'd5:    p = 7'h6D;
            4'd6:    p = 7'h7D;
            4'd7:    p = 7'h07;
            4'd8:    p = 7'h7F;
            4'd9:    p = 7'h6F;
            default: p = 7'h00;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
    parameter int DIV = 48_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
    import tl_pkg::*;
#(
    parameter int MAIN_GO_S = 45,
    parameter int SIDE_GO_S = 25,
    parameter int WARN_S    = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    output logic [3:0] tens,
    output logic [3:0] ones,
    output lamp_t      main_lamp,
    output lamp_t      side_lamp
);
    localparam logic [3:0] MG_T = 4'(MAIN_GO_S / 10);
    localparam logic [3:0] MG_O = 4'(MAIN_GO_S % 10);
    localparam logic [3:0] SG_T = 4'(SIDE_GO_S / 10);
    localparam logic [3:0] SG_O = 4'(SIDE_GO_S % 10);
    localparam logic [3:0] WN_T = 4'(WARN_S / 10);
    localparam logic [3:0] WN_O = 4'(WARN_S % 10);

    phase_e     state, nxt;
    logic       at_last;
    logic [3:0] load_t, load_o;

    assign at_last = (tens == 4'd0) && (ones == 4'd1);

    // Next phase: moves only on the strobe after the count shows 1.
    always_comb begin
        nxt = state;
        if (tick && at_last) begin
            unique case (state)
                PH_MAIN_GO:   nxt = PH_MAIN_WARN;
                PH_MAIN_WARN: nxt = PH_SIDE_GO;
                PH_SIDE_GO:   nxt = PH_SIDE_WARN;
                PH_SIDE_WARN: nxt = PH_MAIN_GO;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_MAIN_GO;
        end else begin
            state <= nxt;
        end
    end

    // Duration of the phase being entered.
    always_comb begin
        unique case (nxt)
            PH_MAIN_GO:   begin load_t = MG_T; load_o = MG_O; end
            PH_SIDE_GO:   begin load_t = SG_T; load_o = SG_O; end
            PH_MAIN_WARN,
            PH_SIDE_WARN: begin load_t = WN_T; load_o = WN_O; end
        endcase
    end

    // BCD countdown.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tens <= MG_T;
            ones <= MG_O;
        end else if (tick) begin
            if (at_last) begin
                tens <= load_t;
                ones <= load_o;
            end else if (ones == 4'd0) begin
                tens <= tens - 4'd1;
                ones <= 4'd9;
            end else begin
                ones <= ones - 4'd1;
            end
        end
    end

    // Lamp outputs by state.
    always_comb begin
        main_lamp = '0;
        side_lamp = '0;
        unique case (state)
            PH_MAIN_GO:   begin main_lamp.green  = 1'b1; side_lamp.red    = 1'b1; end
            PH_MAIN_WARN: begin main_lamp.yellow = 1'b1; side_lamp.red    = 1'b1; end
            PH_SIDE_GO:   begin main_lamp.red    = 1'b1; side_lamp.green  = 1'b1; end
            PH_SIDE_WARN: begin main_lamp.red    = 1'b1; side_lamp.yellow = 1'b1; end
        endcase
    end
endmodule

// File: rtl/scan_drv.sv
module scan_drv
    import tl_pkg::*;
#(
    parameter int POSITIONS = 8,
    parameter int SCAN_DIV  = 24_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           tens,
    input  logic [3:0]           ones,
    output logic [POSITIONS-1:0] dig_sel_n,
    output logic [SEG_W-1:0]     seg_n
);
    localparam int PW = (POSITIONS > 1) ? $clog2(POSITIONS) : 1;
    localparam logic [PW-1:0] POS_LAST = PW'(POSITIONS - 1);

    logic          step;
    logic [PW-1:0] pos;
    logic [3:0]    digit;
    logic          shown;

    tick_gen #(.DIV(SCAN_DIV)) u_scan_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (step)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (step) begin
            pos <= (pos == POS_LAST) ? '0 : pos + 1'b1;
        end
    end

    for (genvar g = 0; g < POSITIONS; g++) begin : g_sel
        assign dig_sel_n[g] = (pos != PW'(g));
    end

    always_comb begin
        shown = 1'b1;
        digit = ones;
        if (pos == PW'(0)) begin
            digit = ones;
        end else if (pos == PW'(1)) begin
            digit = tens;
        end else begin
            shown = 1'b0;
        end
    end

    assign seg_n = shown ? ~seg_pattern(digit) : {SEG_W{1'b1}};
endmodule

// File: rtl/traffic_ctrl.sv
module traffic_ctrl
    import tl_pkg::*;
#(
    parameter int SEC_DIV   = 48_000_000,
    parameter int SCAN_DIV  = 24_000,
    parameter int MAIN_GO_S = 45,
    parameter int SIDE_GO_S = 25,
    parameter int WARN_S    = 5,
    parameter int POSITIONS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 main_red_n,
    output logic                 main_yel_n,
    output logic                 main_grn_n,
    output logic                 side_red_n,
    output logic                 side_yel_n,
    output logic                 side_grn_n,
    output logic [POSITIONS-1:0] dig_sel_n,
    output logic [6:0]           seg_n
);
    logic       sec_tick;
    logic [3:0] cnt_tens, cnt_ones;
    lamp_t      main_lamp, side_lamp;

    tick_gen #(.DIV(SEC_DIV)) u_sec (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sec_tick)
    );

    phase_fsm #(
        .MAIN_GO_S (MAIN_GO_S),
        .SIDE_GO_S (SIDE_GO_S),
        .WARN_S    (WARN_S)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sec_tick),
        .tens      (cnt_tens),
        .ones      (cnt_ones),
        .main_lamp (main_lamp),
        .side_lamp (side_lamp)
    );

    scan_drv #(
        .POSITIONS (POSITIONS),
        .SCAN_DIV  (SCAN_DIV)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .tens      (cnt_tens),
        .ones      (cnt_ones),
        .dig_sel_n (dig_sel_n),
        .seg_n     (seg_n)
    );

    assign main_red_n = ~main_lamp.red;
    assign main_yel_n = ~main_lamp.yellow;
    assign main_grn_n = ~main_lamp.green;
    assign side_red_n = ~side_lamp.red;
    assign side_yel_n = ~side_lamp.yellow;
    assign side_grn_n = ~side_lamp.green;
endmodule

// File: rtl/traffic_ctrl_chk.sv
module traffic_ctrl_chk #(
    parameter int POSITIONS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sec_tick,
    input logic                 main_red_n,
    input logic                 main_yel_n,
    input logic                 main_grn_n,
    input logic                 side_red_n,
    input logic                 side_yel_n,
    input logic                 side_grn_n,
    input logic [POSITIONS-1:0] dig_sel_n,
    input logic [6:0]           seg_n
);
    logic [5:0] lamps;
    assign lamps = {main_red_n, main_yel_n, main_grn_n, side_red_n, side_yel_n, side_grn_n};

    AST_MAIN_ONE_LAMP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({main_red_n, main_yel_n, main_grn_n}) == 2); // R6
    AST_SIDE_ONE_LAMP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({side_red_n, side_yel_n, side_grn_n}) == 2); // R6
    AST_SIDE_HELD_RED: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_grn_n || !main_yel_n) |-> !side_red_n); // R6
    AST_MAIN_HELD_RED: assert property (@(posedge clk) disable iff (!rst_n)
        (!side_grn_n || !side_yel_n) |-> !main_red_n); // R6
    AST_LAMPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(lamps)); // R8
    AST_MAIN_GO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_grn_n) |-> !main_yel_n); // R2
    AST_MAIN_WARN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_yel_n) |-> (!main_red_n && !side_grn_n)); // R2
    AST_SIDE_GO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(side_grn_n) |-> !side_yel_n); // R2
    AST_SIDE_WARN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(side_yel_n) |-> (!side_red_n && !main_grn_n)); // R2
    AST_DIG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~dig_sel_n) == 1); // R10
    AST_BLANK_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_sel_n[1:0] == 2'b11) |-> (seg_n == 7'h7F)); // R11
endmodule

bind traffic_ctrl traffic_ctrl_chk #(.POSITIONS(POSITIONS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .main_red_n (main_red_n),
    .main_yel_n (main_yel_n),
    .main_grn_n (main_grn_n),
    .side_red_n (side_red_n),
    .side_yel_n (side_yel_n),
    .side_grn_n (side_grn_n),
    .dig_sel_n  (dig_sel_n),
    .seg_n      (seg_n)
);

// File: tb/test_traffic_ctrl.sv
`timescale 1ns/1ps
module test_traffic_ctrl;
    localparam int SEC  = 40;
    localparam int SCAN = 2;
    localparam int NPOS = 8;
    localparam logic [5:0] L_MG = 6'b110011;
    localparam logic [5:0] L_MY = 6'b101011;
    localparam logic [5:0] L_SG = 6'b011110;
    localparam logic [5:0] L_SY = 6'b011101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic main_red_n, main_yel_n, main_grn_n, side_red_n, side_yel_n, side_grn_n;
    logic [NPOS-1:0] dig_sel_n;
    logic [6:0] seg_n;

    int total = 0;
    int bad = 0;
    int ecount = 0;
    bit finished = 0;

    typedef struct {
        logic [5:0] lamps;
        int         value;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    traffic_ctrl #(
        .SEC_DIV (SEC), .SCAN_DIV (SCAN),
        .MAIN_GO_S (45), .SIDE_GO_S (25), .WARN_S (5), .POSITIONS (NPOS)
    ) i_traffic_ctrl (
        .clk (clk), .rst_n (rst_n),
        .main_red_n (main_red_n), .main_yel_n (main_yel_n), .main_grn_n (main_grn_n),
        .side_red_n (side_red_n), .side_yel_n (side_yel_n), .side_grn_n (side_grn_n),
        .dig_sel_n (dig_sel_n), .seg_n (seg_n)
    );

    always @(posedge clk) begin
        if (rst_n) ecount <= ecount + 1;
        else       ecount <= 0;
    end

    function automatic logic [6:0] pat(input int d);
        case (d)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
            4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
            8: return 7'h7F;  9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic logic [5:0] lamps_now();
        return {main_red_n, main_yel_n, main_grn_n, side_red_n, side_yel_n, side_grn_n};
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: one expected item per second of the phase.
    task automatic push_phase(input logic [5:0] l, input int dur, input string tag);
        for (int v = dur; v >= 1; v--) begin
            exp_t e;
            e.lamps = l; e.value = v; e.tag = tag;
            sb.push_back(e);
        end
    endtask

    task automatic wait_edge(input int n);
        while (ecount < n) @(negedge clk);
    endtask

    task automatic check_reset_view();
        chk(lamps_now() == L_MG, "R1", "reset lamps", lamps_now(), L_MG);
        chk(dig_sel_n == 8'hFE, "R1", "reset select", dig_sel_n, 8'hFE);
        chk(seg_n == ~pat(5), "R1", "reset ones digit", seg_n, ~pat(5));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int nsec;
        for (int c = 0; c < 2; c++) begin
            push_phase(L_MG, 45, "R3");
            push_phase(L_MY, 5,  "R5");
            push_phase(L_SG, 25, "R4");
            push_phase(L_SY, 5,  "R5");
        end
        nsec = sb.size();

        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check_reset_view();                       // R1
        rst_n = 1'b1;

        for (int s = 0; s < nsec; s++) begin
            exp_t e;
            logic [6:0] seen_seg [NPOS];
            int seen_cnt [NPOS];
            int prev;
            e = sb.pop_front();
            for (int p = 0; p < NPOS; p++) begin seen_cnt[p] = 0; seen_seg[p] = 7'h00; end

            wait_edge(s * SEC + 2);
            chk(lamps_now() == e.lamps, {"R2/R6/", e.tag}, $sformatf("lamps at second %0d", s),
                lamps_now(), e.lamps);

            prev = -1;
            for (int k = 0; k < NPOS * SCAN; k++) begin
                int pos;
                pos = -1;
                chk($countones(~dig_sel_n) == 1, "R10", "one select low",
                    $countones(~dig_sel_n), 1);
                for (int p = 0; p < NPOS; p++) if (!dig_sel_n[p]) pos = p;
                if (pos >= 0) begin
                    if (prev >= 0)
                        chk(pos == prev || pos == (prev + 1) % NPOS, "R10", "scan order",
                            pos, (prev + 1) % NPOS);
                    seen_cnt[pos]++;
                    seen_seg[pos] = seg_n;
                    prev = pos;
                end
                @(negedge clk);
            end
            for (int p = 0; p < NPOS; p++)
                chk(seen_cnt[p] == SCAN, "R10", $sformatf("dwell of position %0d", p),
                    seen_cnt[p], SCAN);
            chk(seen_seg[0] == ~pat(e.value % 10), "R7/R9", $sformatf("ones at second %0d", s),
                seen_seg[0], ~pat(e.value % 10));
            chk(seen_seg[1] == ~pat(e.value / 10), "R7/R9", $sformatf("tens at second %0d", s),
                seen_seg[1], ~pat(e.value / 10));
            for (int p = 2; p < NPOS; p++)
                chk(seen_seg[p] == 7'h7F, "R11", $sformatf("blank position %0d", p),
                    seen_seg[p], 7'h7F);

            // Last cycle before the next strobe: nothing has moved yet.
            wait_edge(s * SEC + SEC - 1);
            chk(lamps_now() == e.lamps, "R8", $sformatf("lamps held to end of second %0d", s),
                lamps_now(), e.lamps);
        end

        // Reset in the middle of a phase returns to main-go with 45.
        wait_edge(nsec * SEC + 7 * SEC + 5);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_view();                       // R1

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule